// File: doc/BRIEF.md
# Row Retention Sweep Sequencer

This block runs an unrefreshed-hold test across every row of every bank of a memory. It works through a simple row-level command port. For each row it fills all words with one uniform pattern and switches periodic refresh off. It then leaves the row alone for a programmed number of clock cycles, reads every word back and counts the bits that no longer match the pattern. Each row's count goes out as one beat on a valid/ready result stream, together with the bank, the row and the pattern used.

Software starts a sweep with a one-cycle strobe and selects either the all-zero or the all-one pattern. It also sets the hold length as a cycle count. The counter is wide enough that holds of many seconds, far beyond the normal refresh period, can be expressed. Refresh stays off from the first hold until the last row of the last bank has been reported. A single-cycle completion flag marks the end of the sweep.

Top module: `ret_sweep_top`

## Requirements
- R1: During a write phase a write command is issued for every word of the row, columns 0 up to WORDS_PER_ROW-1 in ascending order, each carrying 16'h0000 when the latched pattern_sel is 0 and 16'hFFFF when it is 1 (the byte 0x00 or 0xFF repeated across the word).
- R2: ref_en is 1 out of reset and while idle. It drops to 0 after the first row is written and stays 0 for the whole sweep, so it is 0 at every read command. It returns to 1 only after the final row of the final bank.
- R3: With hold length N = max(wait_cycles, 1), the first read command of a row comes exactly N+2 cycles after that row's last write command.
- R4: The error count of a row is the sum, over its words, of the number of set bits in read data XOR the expected pattern word.
- R5: The error count saturates at 2^ERR_W-1 and never wraps.
- R6: Exactly one result beat is produced per row. Rows go in ascending order within a bank and banks in ascending order, and each beat carries the bank, row, latched pattern and count.
- R7: While res_valid is 1 and res_ready is 0, the sequencer stalls and every result field holds its value.
- R8: done is a one-cycle pulse that follows acceptance of the final beat. In that cycle busy is 0 and ref_en is 1.
- R9: A start strobe while busy is 1 has no effect: pattern, hold length and sequence continue unchanged.
- R10: After reset busy, done, res_valid and mem_cmd_valid are 0 and ref_en is 1.
- R11: After the hold, each column is read exactly once in ascending order, with at most one read outstanding, and the next read is issued only after mem_rd_valid returns data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle sweep start strobe |
| pattern_sel | input | 1 | 0: all-zero pattern, 1: all-one pattern |
| wait_cycles | input | WAIT_W | Hold length in cycles (0 acts as 1) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle sweep completion pulse |
| ref_en | output | 1 | Periodic refresh enable to the memory |
| mem_cmd_valid | output | 1 | Command issued this cycle |
| mem_cmd_write | output | 1 | 1 write, 0 read |
| mem_bank | output | BANK_W | Command bank |
| mem_row | output | ROW_W | Command row |
| mem_col | output | COL_W | Command word column |
| mem_wdata | output | DATA_W | Write data |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DATA_W | Returned read data |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result consumer ready |
| res_bank | output | BANK_W | Bank of the result |
| res_row | output | ROW_W | Row of the result |
| res_pattern | output | 1 | Pattern used for the row |
| res_errs | output | ERR_W | Flipped-bit count of the row |

## Verification
The sweeps inject flip masks that differ per row, including an all-clear row and a fully flipped row whose count would exceed the counter. A design that wraps instead of saturating reports a small number on that row, and one that drops or doubles a word gives a count that is off by that word's flips. The hold gap is measured for a zero, a short and a long hold, so an off-by-one in the timer load or the exit shows up as a gap of the wrong length. The result port is stalled in a repeating pattern, and a second start is issued in the middle of a sweep. A design that advances under backpressure loses or repeats beats, and one that honours the late start emits beats with the wrong pattern or restarts the row order.

// File: rtl/ret_sweep_pkg.sv
package ret_sweep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WRITE_ROW = 3'd1,
        ST_DISABLE   = 3'd2,
        ST_HOLD      = 3'd3,
        ST_READ_ROW  = 3'd4,
        ST_REPORT    = 3'd5,
        ST_NEXT      = 3'd6
    } sweep_state_e;
endpackage

// File: rtl/ret_idle_timer.sv
module ret_idle_timer #(
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] len,
    input  logic              run,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (len == '0) ? WAIT_W'(1) : len;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == WAIT_W'(1));

    AST_HOLD_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q != '0); // R3
endmodule

// File: rtl/ret_err_accum.sv
module ret_err_accum #(
    parameter int DATA_W = 16,
    parameter int ERR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam int PC_W  = $clog2(DATA_W + 1);
    localparam int SUM_W = ((ERR_W > PC_W) ? ERR_W : PC_W) + 1;
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << ERR_W) - 1);

    logic [DATA_W-1:0] diff;
    logic [PC_W-1:0]   pc;
    logic [SUM_W-1:0]  sum;
    logic [ERR_W-1:0]  err_d, err_q;

    assign diff = rd_data ^ exp_data;

    always_comb begin
        pc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pc = pc + PC_W'(diff[i]);
        end
    end

    always_comb begin
        sum   = SUM_W'(err_q) + SUM_W'(pc);
        err_d = err_q;
        if (clr) begin
            err_d = '0;
        end else if (add) begin
            err_d = (sum > SAT_MAX) ? ERR_W'(SAT_MAX) : sum[ERR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_cnt = err_q;

    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> err_q >= $past(err_q)); // R5
endmodule

// File: rtl/ret_sweep_top.sv
module ret_sweep_top
    import ret_sweep_pkg::*;
#(
    parameter int NUM_BANKS     = 2,
    parameter int NUM_ROWS      = 4,
    parameter int WORDS_PER_ROW = 4,
    parameter int DATA_W        = 16,
    parameter int WAIT_W        = 32,
    parameter int ERR_W         = 5,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W  = (WORDS_PER_ROW > 1) ? $clog2(WORDS_PER_ROW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pattern_sel,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              busy,
    output logic              done,
    output logic              ref_en,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [BANK_W-1:0] mem_bank,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [BANK_W-1:0] res_bank,
    output logic [ROW_W-1:0]  res_row,
    output logic              res_pattern,
    output logic [ERR_W-1:0]  res_errs
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(WORDS_PER_ROW - 1);

    typedef struct packed {
        sweep_state_e      st;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              pend;
        logic              pat;
        logic [WAIT_W-1:0] hold_len;
        logic              ref_on;
        logic              fin;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic              tmr_load;
    logic              tmr_run;
    logic              tmr_expired;
    logic              acc_clr;
    logic              acc_add;
    logic [DATA_W-1:0] pat_word;
    logic [ERR_W-1:0]  row_errs;

    assign pat_word = {DATA_W{seq_q.pat}};
    assign tmr_run  = (seq_q.st == ST_HOLD);

    ret_idle_timer #(.WAIT_W(WAIT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (seq_q.hold_len),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    ret_err_accum #(.DATA_W(DATA_W), .ERR_W(ERR_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add      (acc_add),
        .rd_data  (mem_rd_data),
        .exp_data (pat_word),
        .err_cnt  (row_errs)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.fin = 1'b0;
        tmr_load = 1'b0;
        acc_clr  = 1'b0;
        acc_add  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st       = ST_WRITE_ROW;
                    seq_d.bank     = '0;
                    seq_d.row      = '0;
                    seq_d.col      = '0;
                    seq_d.pend     = 1'b0;
                    seq_d.pat      = pattern_sel;
                    seq_d.hold_len = wait_cycles;
                end
            end
            ST_WRITE_ROW: begin
                if (seq_q.col == LAST_COL) begin
                    seq_d.col = '0;
                    seq_d.st  = ST_DISABLE;
                end else begin
                    seq_d.col = seq_q.col + COL_W'(1);
                end
            end
            ST_DISABLE: begin
                seq_d.ref_on = 1'b0;
                tmr_load     = 1'b1;
                acc_clr      = 1'b1;
                seq_d.st     = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    seq_d.st   = ST_READ_ROW;
                    seq_d.col  = '0;
                    seq_d.pend = 1'b0;
                end
            end
            ST_READ_ROW: begin
                if (!seq_q.pend) begin
                    seq_d.pend = 1'b1;
                end else if (mem_rd_valid) begin
                    acc_add    = 1'b1;
                    seq_d.pend = 1'b0;
                    if (seq_q.col == LAST_COL) begin
                        seq_d.col = '0;
                        seq_d.st  = ST_REPORT;
                    end else begin
                        seq_d.col = seq_q.col + COL_W'(1);
                    end
                end
            end
            ST_REPORT: begin
                if (res_ready) seq_d.st = ST_NEXT;
            end
            ST_NEXT: begin
                if (seq_q.bank == LAST_BANK && seq_q.row == LAST_ROW) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.ref_on = 1'b1;
                    seq_d.fin    = 1'b1;
                end else begin
                    seq_d.st = ST_WRITE_ROW;
                    if (seq_q.row == LAST_ROW) begin
                        seq_d.row  = '0;
                        seq_d.bank = seq_q.bank + BANK_W'(1);
                    end else begin
                        seq_d.row = seq_q.row + ROW_W'(1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.st       <= ST_IDLE;
            seq_q.ref_on   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy          = (seq_q.st != ST_IDLE);
    assign done          = seq_q.fin;
    assign ref_en        = seq_q.ref_on;
    assign mem_cmd_write = (seq_q.st == ST_WRITE_ROW);
    assign mem_cmd_valid = mem_cmd_write || (seq_q.st == ST_READ_ROW && !seq_q.pend);
    assign mem_bank      = seq_q.bank;
    assign mem_row       = seq_q.row;
    assign mem_col       = seq_q.col;
    assign mem_wdata     = pat_word;
    assign res_valid     = (seq_q.st == ST_REPORT);
    assign res_bank      = seq_q.bank;
    assign res_row       = seq_q.row;
    assign res_pattern   = seq_q.pat;
    assign res_errs      = row_errs;

    AST_REF_OFF_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_write) |-> !ref_en); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_errs)
                                       && $stable(res_row) && $stable(res_bank))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && ref_en)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(res_pattern)); // R9
endmodule

// File: tb/ret_sweep_top_tb_top.sv
module ret_sweep_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NR = 4;
    localparam int NW = 4;
    localparam int DW = 16;
    localparam int WW = 32;
    localparam int EW = 5;
    localparam int SAT = (1 << EW) - 1;
    localparam int NBEATS = NB * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pattern_sel = 1'b0;
    logic [WW-1:0] wait_cycles = '0;
    logic          busy, done, ref_en;
    logic          mem_cmd_valid, mem_cmd_write;
    logic [0:0]    mem_bank;
    logic [1:0]    mem_row;
    logic [1:0]    mem_col;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          res_valid;
    logic          res_ready = 1'b1;
    logic [0:0]    res_bank;
    logic [1:0]    res_row;
    logic          res_pattern;
    logic [EW-1:0] res_errs;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_sweep_top #(.NUM_BANKS(NB), .NUM_ROWS(NR), .WORDS_PER_ROW(NW),
                    .DATA_W(DW), .WAIT_W(WW), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern_sel(pattern_sel),
        .wait_cycles(wait_cycles), .busy(busy), .done(done), .ref_en(ref_en),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_bank(mem_bank), .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .res_valid(res_valid), .res_ready(res_ready),
        .res_bank(res_bank), .res_row(res_row), .res_pattern(res_pattern),
        .res_errs(res_errs)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [DW-1:0] store [NB][NR][NW];
    logic [DW-1:0] flips [NB][NR][NW];
    int            exp_errs [NBEATS];
    logic          exp_pat;
    int            exp_gap;
    int            throttle;
    int            cyc = 0;
    int            last_wr = 0;
    int            rd_col_exp = 0;
    int            wr_col_exp = 0;
    int            beat = 0;
    int            done_cnt = 0;
    logic          ref_low_seen = 1'b0;
    logic          pipe_v = 1'b0;
    logic [DW-1:0] pipe_d = '0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model and stream monitor, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        mem_rd_valid = pipe_v;
        mem_rd_data  = pipe_d;
        pipe_v = 1'b0;
        if (rst_n && mem_cmd_valid) begin
            if (mem_cmd_write) begin
                chk(mem_wdata == {DW{exp_pat}}, "R1 write data", int'(mem_wdata), exp_pat ? 16'hFFFF : 0);
                chk(int'(mem_col) == wr_col_exp, "R1 write column", int'(mem_col), wr_col_exp);
                wr_col_exp = (wr_col_exp + 1) % NW;
                store[mem_bank][mem_row][mem_col] = mem_wdata;
                last_wr = cyc;
                rd_col_exp = 0;
            end else begin
                chk(ref_en == 1'b0, "R2 refresh at read", int'(ref_en), 0);
                chk(int'(mem_col) == rd_col_exp, "R11 read column", int'(mem_col), rd_col_exp);
                if (rd_col_exp == 0)
                    chk(cyc - last_wr == exp_gap, "R3 hold gap", cyc - last_wr, exp_gap);
                rd_col_exp++;
                pipe_v = 1'b1;
                pipe_d = store[mem_bank][mem_row][mem_col] ^ flips[mem_bank][mem_row][mem_col];
            end
        end
        if (rst_n && busy && !ref_en && !ref_low_seen) ref_low_seen = 1'b1;
        if (rst_n && busy && ref_low_seen && !done)
            chk(ref_en == 1'b0, "R2 refresh held off", int'(ref_en), 0);
        if (done) begin
            done_cnt++;
            chk(!busy && ref_en, "R8 idle and refresh on at done", int'({busy, ref_en}), 1);
            chk(beat == NBEATS, "R8 done after final beat", beat, NBEATS);
            ref_low_seen = 1'b0;
        end
        res_ready = (throttle == 0) ? 1'b1 : ((cyc % throttle) != 0);
        if (res_valid && res_ready) begin
            chk(int'(res_bank) == beat / NR, "R6 bank order", int'(res_bank), beat / NR);
            chk(int'(res_row) == beat % NR, "R6 row order", int'(res_row), beat % NR);
            chk(res_pattern == exp_pat, "R9 pattern kept", int'(res_pattern), int'(exp_pat));
            if (beat < NBEATS)
                chk(int'(res_errs) == exp_errs[beat], "R4 R5 row error count", int'(res_errs), exp_errs[beat]);
            beat++;
        end
    end

    task automatic compute_expect();
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++) begin
                int s = 0;
                for (int c = 0; c < NW; c++) s += $countones(flips[b][r][c]);
                exp_errs[b*NR + r] = (s > SAT) ? SAT : s;
            end
    endtask

    task automatic run_sweep(input logic pat, input int hold, input int thr, input bit late_start);
        int wd;
        exp_pat = pat;
        exp_gap = ((hold == 0) ? 1 : hold) + 2;
        throttle = thr;
        beat = 0;
        done_cnt = 0;
        wr_col_exp = 0;
        compute_expect();
        @(negedge clk);
        pattern_sel = pat;
        wait_cycles = WW'(hold);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wd = 0;
        while (done_cnt == 0 && wd < 20000) begin
            @(negedge clk);
            wd++;
            if (late_start && wd == 60) begin
                pattern_sel = ~pat;
                wait_cycles = WW'(hold + 7);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        chk(wd < 20000, "R8 sweep completes (watchdog)", wd, 0);
        repeat (5) @(negedge clk);
        chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        chk(beat == NBEATS, "R6 one beat per row", beat, NBEATS);
        chk(!busy && ref_en, "R9 no restart after sweep", int'({busy, ref_en}), 1);
    endtask

    initial begin
        exp_pat = 1'b0;
        exp_gap = 3;
        throttle = 0;
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NW; c++) begin
                    store[b][r][c] = '0;
                    flips[b][r][c] = '0;
                end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !res_valid && !mem_cmd_valid, "R10 reset outputs",
            int'({busy, done, res_valid, mem_cmd_valid}), 0);
        chk(ref_en == 1'b1, "R10 refresh on in reset", int'(ref_en), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && ref_en, "R10 idle after reset", int'({busy, ref_en}), 1);

        // sweep A: zero pattern, varied sparse flips, backpressure, late start
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NW; c++)
                    flips[b][r][c] = (DW'(1) << ((b*7 + r*3 + c) % DW))
                                   | ((c == r) ? (DW'(3) << (b + r)) : DW'(0));
        run_sweep(1'b0, 5, 3, 1'b1);

        // sweep B: one pattern, zero hold, clean row and saturating row
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NW; c++)
                    flips[b][r][c] = DW'((b + 1) * (r + 1) * (c + 5));
        for (int c = 0; c < NW; c++) begin
            flips[0][1][c] = '0;
            flips[1][2][c] = '1;
        end
        flips[0][3][0] = '1;
        run_sweep(1'b1, 0, 0, 1'b0);

        // sweep C: long hold, stall every other cycle
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NW; c++)
                    flips[b][r][c] = (r == NR - 1) ? DW'(16'h8001) : DW'(0);
        run_sweep(1'b1, 40, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule